// File: doc/BRIEF.md
# Multiplicative Divide and Square-Root Sequencer

This block is the control for divide and square-root operations that share a fully pipelined multiplier with a four-cycle latency. It takes a start strobe with an operation select, a precision select and a fast-path flag. It then issues a fixed program of multiplies: a reciprocal-seed wait, a series of convergence groups, a final multiply and a back-multiply for the remainder. For each issued multiply it drives the kind of step and the operand-source selects. Four cycles later it drives a write-enable strobe for the register that captures the product. The multiplier arithmetic and the registers themselves belong to the datapath beside it and are not part of this block.

Lower precisions run fewer convergence groups and so finish sooner. Because the latency varies, the block announces the result cycle seven cycles in advance. It also flags, three cycles ahead, every multiplier slot inside the program that it will leave empty, so that an outside scheduler can place an independent multiply there. When the datapath reports that the divisor is an exact power of two or the dividend is zero, the convergence groups are skipped and the operation takes a fixed 11 cycles.

Top module: `dsq_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `issueValid`, `wbEn`, `freeSlotAhead`, `doneAhead` and `resultValid` are all low and `issueKind` is 0.
- R2: A start is taken only when `busy` is low. The cycle in which it is seen is tick 0, and `busy` is high from tick 1 through the result tick. A start that arrives while `busy` is high, including in the result tick, is ignored. The operation, precision and fast flag are captured at the start, and later changes to them have no effect.
- R3: Division issue codes (`issueKind`: 0 none, 1 denominator, 2 numerator, 3 square, 4 final, 5 back-multiply). For group g (g = 0..N), denominator is issued at tick 3+4g and numerator at tick 4+4g.
- R4: N, the number of refinement iterations, is 1 for `precSel`=0 (single), 2 for 1 (double), and 3 for 2 (extended) and for 3 (internal).
- R5: Square-root schedule. Group 0 issues square at tick 3 and denominator at tick 4. For g = 1..N, group g issues numerator at 3+4g, square at 4+4g and denominator at 5+4g.
- R6: Without the fast path, final is issued at tick 8+4N and back-multiply at tick 12+4N. No other issue happens.
- R7: `resultValid` pulses for one cycle at tick 16+4N, four cycles after the back-multiply. `busy` drops on the next cycle.
- R8: With `fastPath` set at start, for either operation and any precision, the only issues are final at tick 3 and back-multiply at tick 7, and `resultValid` comes at tick 11.
- R9: `freeSlotAhead` is high at tick t exactly when `busy` is high, t+3 is below the result tick, and nothing is issued at tick t+3.
- R10: `doneAhead` is a one-cycle pulse exactly seven cycles before `resultValid`.
- R11: Four cycles after each issue of kind 1, 2, 3 or 4, exactly `wbEn` bit (kind-1) is high. At all other times `wbEn` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe |
| opSqrt | input | 1 | 1 selects square root, 0 division |
| precSel | input | 2 | Target precision: 0 single, 1 double, 2 extended, 3 internal |
| fastPath | input | 1 | Divisor is a power of two or dividend is zero |
| busy | output | 1 | Operation in progress |
| issueValid | output | 1 | A multiply is issued this cycle |
| issueKind | output | 3 | Step code of the issued multiply |
| srcASel | output | 3 | Operand A source select |
| srcBSel | output | 3 | Operand B source select |
| wbEn | output | 4 | Product capture strobes: denominator, numerator, square, quotient |
| freeSlotAhead | output | 1 | The multiplier slot three cycles ahead is unused |
| doneAhead | output | 1 | Result arrives in seven cycles |
| resultValid | output | 1 | Result cycle |

## Verification
Division is run at all four precision codes, so that each iteration count and the merging of extended with internal precision show up in both issue timing and result tick. Square root is run at single and extended precision, which separates its three-slot groups and its different free-slot pattern from division. The fast path is run for both operations at different precisions to show that its latency does not depend on them. Runs with starts in the middle of an operation, starts in the result tick, input changes while busy, and back-to-back starts in the first idle cycle tell a correctly ignored strobe from an accepted one.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    STEP_NONE   = 3'd0,
    STEP_DENOM  = 3'd1,
    STEP_NUMER  = 3'd2,
    STEP_SQUARE = 3'd3,
    STEP_FINAL  = 3'd4,
    STEP_BACK   = 3'd5
  } stepE;

  // operand A sources
  localparam logic [2:0] A_EST  = 3'd0;
  localparam logic [2:0] A_DEN  = 3'd1;
  localparam logic [2:0] A_NUM  = 3'd2;
  localparam logic [2:0] A_SQR  = 3'd3;
  localparam logic [2:0] A_QUO  = 3'd4;
  localparam logic [2:0] A_CORR = 3'd5;

  // operand B sources
  localparam logic [2:0] B_OPA  = 3'd0;
  localparam logic [2:0] B_OPB  = 3'd1;
  localparam logic [2:0] B_CORR = 3'd2;
  localparam logic [2:0] B_QUO  = 3'd3;
  localparam logic [2:0] B_EST  = 3'd4;

  // control -> issue strobes and captured configuration
  typedef struct packed {
    logic             busy;
    logic [CNT_W-1:0] tick;
    logic [CNT_W-1:0] doneTick;
    logic             sqrtOp;
    logic [1:0]       iters;
    logic             fast;
  } seqCtrlT;

endpackage

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int MUL_LAT = 4,
  parameter int EST_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       opSqrt,
  input  logic [1:0] precSel,
  input  logic       fastPath,
  output seqCtrlT    seqCtrl
);

  localparam int FAST_LAT = EST_CYC + 2 * MUL_LAT;

  seqCtrlT   cur;
  logic [1:0] startIters;
  logic [CNT_W-1:0] startDone;
  logic lastTick;

  always_comb begin
    case (precSel)
      2'd0:    startIters = 2'd1;
      2'd1:    startIters = 2'd2;
      default: startIters = 2'd3;
    endcase
    if (fastPath)
      startDone = CNT_W'(FAST_LAT);
    else
      startDone = CNT_W'(EST_CYC + MUL_LAT * (int'(startIters) + 3) + 1);
  end

  assign lastTick = cur.busy && (cur.tick == cur.doneTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '0;
    end else if (!cur.busy) begin
      if (startValid) begin
        cur.busy     <= 1'b1;
        cur.tick     <= CNT_W'(1);
        cur.doneTick <= startDone;
        cur.sqrtOp   <= opSqrt;
        cur.iters    <= startIters;
        cur.fast     <= fastPath;
      end
    end else if (lastTick) begin
      cur.busy <= 1'b0;
      cur.tick <= '0;
    end else begin
      cur.tick <= cur.tick + CNT_W'(1);
    end
  end

  assign seqCtrl = cur;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cur.busy && !lastTick |=> cur.busy); // R2
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cur.busy) |-> $past(startValid)); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cur.busy && $past(cur.busy) |-> $stable(cur.sqrtOp) && $stable(cur.iters) && $stable(cur.fast)); // R2

endmodule

// File: rtl/dsq_issue.sv
module dsq_issue
  import dsq_pkg::*;
#(
  parameter int MUL_LAT   = 4,
  parameter int EST_CYC   = 3,
  parameter int SLOT_LEAD = 3,
  parameter int NOTE_LEAD = 7,
  parameter int WB_W      = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqCtrlT         seqCtrl,
  output logic            issueValid,
  output logic [2:0]      issueKind,
  output logic [2:0]      srcASel,
  output logic [2:0]      srcBSel,
  output logic [WB_W-1:0] wbEn,
  output logic            freeSlotAhead,
  output logic            doneAhead,
  output logic            resultValid
);

  function automatic stepE stepAt(input int t, input logic sq,
                                  input logic [1:0] it, input logic fst);
    int   rel;
    int   grp;
    int   off;
    stepE s;
    s = STEP_NONE;
    if (fst) begin
      if (t == EST_CYC) s = STEP_FINAL;
      else if (t == EST_CYC + MUL_LAT) s = STEP_BACK;
    end else if (t >= EST_CYC) begin
      rel = t - EST_CYC;
      grp = rel / MUL_LAT;
      off = rel % MUL_LAT;
      if (grp <= int'(it)) begin
        if (!sq) begin
          if (off == 0) s = STEP_DENOM;
          else if (off == 1) s = STEP_NUMER;
        end else if (grp == 0) begin
          if (off == 0) s = STEP_SQUARE;
          else if (off == 1) s = STEP_DENOM;
        end else begin
          if (off == 0) s = STEP_NUMER;
          else if (off == 1) s = STEP_SQUARE;
          else if (off == 2) s = STEP_DENOM;
        end
      end else if (grp == int'(it) + 1 && off == 1) begin
        s = STEP_FINAL;
      end else if (grp == int'(it) + 2 && off == 1) begin
        s = STEP_BACK;
      end
    end
    return s;
  endfunction

  int   tNow;
  int   tDone;
  stepE curStep;
  stepE aheadStep;
  stepE wbStep;
  logic firstGrp;

  always_comb begin
    tNow     = int'(seqCtrl.tick);
    tDone    = int'(seqCtrl.doneTick);
    firstGrp = tNow < EST_CYC + MUL_LAT;
    curStep  = seqCtrl.busy ? stepAt(tNow, seqCtrl.sqrtOp, seqCtrl.iters, seqCtrl.fast)
                            : STEP_NONE;
    aheadStep = stepAt(tNow + SLOT_LEAD, seqCtrl.sqrtOp, seqCtrl.iters, seqCtrl.fast);
    wbStep    = (seqCtrl.busy && tNow >= MUL_LAT)
              ? stepAt(tNow - MUL_LAT, seqCtrl.sqrtOp, seqCtrl.iters, seqCtrl.fast)
              : STEP_NONE;
  end

  // operand routing per step
  always_comb begin
    srcASel = A_EST;
    srcBSel = B_OPA;
    case (curStep)
      STEP_DENOM: begin
        if (firstGrp) begin
          srcASel = A_EST;
          srcBSel = seqCtrl.sqrtOp ? B_OPA : B_OPB;
        end else begin
          srcASel = A_DEN;
          srcBSel = B_CORR;
        end
      end
      STEP_NUMER: begin
        if (seqCtrl.sqrtOp) begin
          srcASel = A_SQR;
          srcBSel = B_OPA;
        end else if (firstGrp) begin
          srcASel = A_EST;
          srcBSel = B_OPA;
        end else begin
          srcASel = A_NUM;
          srcBSel = B_CORR;
        end
      end
      STEP_SQUARE: begin
        srcASel = firstGrp ? A_EST : A_CORR;
        srcBSel = firstGrp ? B_EST : B_CORR;
      end
      STEP_FINAL: begin
        if (seqCtrl.fast) begin
          srcASel = A_EST;
          srcBSel = B_OPA;
        end else begin
          srcASel = seqCtrl.sqrtOp ? A_DEN : A_NUM;
          srcBSel = B_CORR;
        end
      end
      STEP_BACK: begin
        srcASel = A_QUO;
        srcBSel = seqCtrl.sqrtOp ? B_QUO : B_OPB;
      end
      default: ;
    endcase
  end

  assign issueValid    = curStep != STEP_NONE;
  assign issueKind     = curStep;
  assign freeSlotAhead = seqCtrl.busy && (tNow + SLOT_LEAD < tDone) && (aheadStep == STEP_NONE);
  assign doneAhead     = seqCtrl.busy && (tNow + NOTE_LEAD == tDone);
  assign resultValid   = seqCtrl.busy && (tNow == tDone);

  for (genvar k = 0; k < WB_W; k++) begin : g_wb
    assign wbEn[k] = wbStep == stepE'(k + 1);

    AST_WB_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
      wbEn[k] |-> $past(issueKind, MUL_LAT) == 3'(k + 1)); // R11
  end

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wbEn)); // R11
  AST_FREE_NOT_OWN: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !$past(freeSlotAhead, SLOT_LEAD)); // R9
  AST_DONE_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(doneAhead, NOTE_LEAD)); // R10
  AST_RESULT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> seqCtrl.busy); // R7
  AST_RESULT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !seqCtrl.busy); // R7
  AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> seqCtrl.busy); // R2

endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
  import dsq_pkg::*;
#(
  parameter int MUL_LAT   = 4,
  parameter int EST_CYC   = 3,
  parameter int SLOT_LEAD = 3,
  parameter int NOTE_LEAD = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       opSqrt,
  input  logic [1:0] precSel,
  input  logic       fastPath,
  output logic       busy,
  output logic       issueValid,
  output logic [2:0] issueKind,
  output logic [2:0] srcASel,
  output logic [2:0] srcBSel,
  output logic [3:0] wbEn,
  output logic       freeSlotAhead,
  output logic       doneAhead,
  output logic       resultValid
);

  seqCtrlT seqCtrl;

  dsq_ctrl #(
    .MUL_LAT (MUL_LAT),
    .EST_CYC (EST_CYC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .opSqrt     (opSqrt),
    .precSel    (precSel),
    .fastPath   (fastPath),
    .seqCtrl    (seqCtrl)
  );

  dsq_issue #(
    .MUL_LAT   (MUL_LAT),
    .EST_CYC   (EST_CYC),
    .SLOT_LEAD (SLOT_LEAD),
    .NOTE_LEAD (NOTE_LEAD),
    .WB_W      (4)
  ) issue_i (
    .clk           (clk),
    .rstN          (rstN),
    .seqCtrl       (seqCtrl),
    .issueValid    (issueValid),
    .issueKind     (issueKind),
    .srcASel       (srcASel),
    .srcBSel       (srcBSel),
    .wbEn          (wbEn),
    .freeSlotAhead (freeSlotAhead),
    .doneAhead     (doneAhead),
    .resultValid   (resultValid)
  );

  assign busy = seqCtrl.busy;

endmodule

// File: tb/dsq_seq_tb.sv
module dsq_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic       opSqrt = 1'b0;
  logic [1:0] precSel = 2'd0;
  logic       fastPath = 1'b0;
  logic       busy, issueValid, freeSlotAhead, doneAhead, resultValid;
  logic [2:0] issueKind, srcASel, srcBSel;
  logic [3:0] wbEn;

  int nChecks = 0;
  int nFail = 0;
  int sampleIdx = 0;
  bit finished = 0;

  typedef struct {
    int         idx;
    logic       busy;
    logic [2:0] kind;
    logic [3:0] wb;
    logic       free;
    logic       early;
    logic       res;
  } expT;

  expT expQ[$];

  always #10 clk = ~clk; // 50 MHz

  dsq_seq dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opSqrt(opSqrt),
    .precSel(precSel), .fastPath(fastPath), .busy(busy),
    .issueValid(issueValid), .issueKind(issueKind), .srcASel(srcASel),
    .srcBSel(srcBSel), .wbEn(wbEn), .freeSlotAhead(freeSlotAhead),
    .doneAhead(doneAhead), .resultValid(resultValid)
  );

  task automatic check(input string req, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s at sample %0d: actual %0d expected %0d", req, sampleIdx, act, expv);
    end
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].idx == sampleIdx) begin
      expT e;
      e = expQ.pop_front();
      check("R2 busy", int'(busy), int'(e.busy));
      check("R3 R4 R5 R6 R8 issueKind", int'(issueKind), int'(e.kind));
      check("R3 R5 issueValid", int'(issueValid), int'(e.kind != 3'd0));
      check("R11 wbEn", int'(wbEn), int'(e.wb));
      check("R9 freeSlotAhead", int'(freeSlotAhead), int'(e.free));
      check("R10 doneAhead", int'(doneAhead), int'(e.early));
      check("R7 R8 resultValid", int'(resultValid), int'(e.res));
    end
    sampleIdx++;
  end

  // expected schedule built from the requirements
  task automatic runOp(input logic sq, input logic [1:0] prec, input logic fst,
                       input bit disturb);
    int plan[64];
    int nIt;
    int doneT;
    int base0;
    foreach (plan[i]) plan[i] = 0;
    nIt = (prec == 2'd0) ? 1 : (prec == 2'd1) ? 2 : 3;        // R4
    if (fst) begin                                           // R8
      plan[3] = 4;
      plan[7] = 5;
      doneT = 11;
    end else begin
      for (int g = 0; g <= nIt; g++) begin
        base0 = 3 + 4 * g;
        if (!sq) begin                                       // R3
          plan[base0] = 1;
          plan[base0 + 1] = 2;
        end else if (g == 0) begin                           // R5
          plan[base0] = 3;
          plan[base0 + 1] = 1;
        end else begin
          plan[base0] = 2;
          plan[base0 + 1] = 3;
          plan[base0 + 2] = 1;
        end
      end
      plan[8 + 4 * nIt] = 4;                                 // R6
      plan[12 + 4 * nIt] = 5;
      doneT = 16 + 4 * nIt;                                  // R7
    end
    for (int t = 0; t <= doneT + 1; t++) begin
      expT e;
      e.idx   = sampleIdx + t;
      e.busy  = (t >= 1 && t <= doneT);
      e.kind  = e.busy ? 3'(plan[t]) : 3'd0;
      e.wb    = 4'd0;
      if (e.busy && t >= 4 && plan[t - 4] >= 1 && plan[t - 4] <= 4)
        e.wb = 4'(1 << (plan[t - 4] - 1));
      e.free  = e.busy && (t + 3 < doneT) && plan[t + 3] == 0;
      e.early = e.busy && (t + 7 == doneT);
      e.res   = e.busy && (t == doneT);
      expQ.push_back(e);
    end
    startValid = 1'b1;
    opSqrt     = sq;
    precSel    = prec;
    fastPath   = fst;
    for (int k = 1; k <= doneT + 1; k++) begin
      @(posedge clk);
      #1;
      startValid = 1'b0;
      if (disturb && (k == 4 || k == doneT)) begin
        startValid = 1'b1;        // R2: ignored while busy
        opSqrt     = ~sq;
        precSel    = ~prec;
        fastPath   = ~fst;
      end
    end
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 busy", int'(busy), 0);
    check("R1 issueValid", int'(issueValid), 0);
    check("R1 issueKind", int'(issueKind), 0);
    check("R1 wbEn", int'(wbEn), 0);
    check("R1 flags", int'({freeSlotAhead, doneAhead, resultValid}), 0);
    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", int'({busy, issueValid, freeSlotAhead, doneAhead, resultValid}), 0);
    @(posedge clk);
    #1;
    runOp(1'b0, 2'd0, 1'b0, 0);   // division single
    runOp(1'b0, 2'd1, 1'b0, 0);   // division double
    runOp(1'b0, 2'd2, 1'b0, 0);   // division extended
    runOp(1'b0, 2'd3, 1'b0, 1);   // division internal with disturbances
    runOp(1'b1, 2'd0, 1'b0, 0);   // square root single
    runOp(1'b1, 2'd2, 1'b0, 1);   // square root extended, disturbed
    runOp(1'b0, 2'd2, 1'b1, 0);   // fast division
    runOp(1'b1, 2'd0, 1'b1, 1);   // fast square root, disturbed
    runOp(1'b1, 2'd1, 1'b0, 0);   // square root double
    startValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R2 queue drained", expQ.size(), 0);
    check("R2 idle at end", int'(busy), 0);
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule